// File: doc/BRIEF.md
# Virtual Address Segment Decoder with Fault Capture

This block takes one 32-bit virtual address per request and sorts it by address window. Two kernel windows are translated by fixed arithmetic and never reach the TLB. The low half of the space, when the error-level flag is clear, and the top quarter are forwarded to an external TLB. The TLB's same-cycle response completes the translation. The block returns the physical address, read and write permissions, and a fault code one clock after the request.

Every fault records three registers on the same edge that raises the fault strobe. The bad-address register receives the full address. The context register receives the faulting page-pair number in its low field and keeps its base field. The entry-hi register receives the page-pair number in its upper field and keeps its 8-bit ID. A seed port loads the kept fields, the context base and the ID, so that the fields a fault must not touch hold a known value.

Top module: `segment_xlate`

## Requirements
- R1: When `user_mode` is 1 and `vaddr[31]` is 1, the request faults with `exc_code` 1 for a read or 2 for a write, `refill` is 0, and the TLB is not requested.
- R2: Addresses 0x00000000–0x7FFFFFFF with `err_level` 0 are mapped. `tlb_req` is 1 in the request cycle only for a mapped address with `req_valid` 1, and `tlb_vaddr` equals `vaddr`.
- R3: Addresses 0x00000000–0x7FFFFFFF with `err_level` 1 are returned unchanged, with `perm_rd` and `perm_wr` both 1 and no fault, whatever the TLB response.
- R4: Addresses 0x80000000–0x9FFFFFFF return the address minus 0x80000000, and 0xA0000000–0xBFFFFFFF return the address minus 0xA0000000. Both have read and write permission, and the TLB response has no effect on them.
- R5: Addresses 0xC0000000–0xFFFFFFFF are mapped through the TLB for kernel accesses.
- R6: For a mapped access the outcome depends on the TLB response:
  - no hit gives `exc_code` 3 (read) or 4 (write) with `refill` 1;
  - a hit on an invalid entry gives 3 or 4 with `refill` 0;
  - a write that hits a clean entry gives 5;
  - otherwise `paddr` equals `tlb_paddr`, `perm_rd` is 1 and `perm_wr` equals `tlb_dirty`.
- R7: On a fault, `bad_vaddr` takes the full faulting address.
- R8: On a fault, `context_reg[22:4]` takes `vaddr[31:13]`, `context_reg[3:0]` becomes 0, and `context_reg[31:23]` keeps the seeded base.
- R9: On a fault, `entry_hi[31:13]` takes `vaddr[31:13]`, `entry_hi[12:8]` is 0, and `entry_hi[7:0]` keeps the seeded ID.
- R10: Results appear with `out_valid` one cycle after `req_valid`. The capture registers change on the edge that raises `fault` and hold otherwise. A faulting result has `paddr` 0 and no permissions. `exc_code` 0 means no fault.
- R11: When `seed_wr` is 1, the next edge loads `seed_ctx_base` into `context_reg[31:23]` and `seed_asid` into `entry_hi[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | 1 for a store, 0 for a load |
| user_mode | input | 1 | Request comes from user mode |
| err_level | input | 1 | Error-level flag |
| tlb_req | output | 1 | Lookup request to the TLB |
| tlb_vaddr | output | 32 | Address presented to the TLB |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_valid | input | 1 | Matching page is valid |
| tlb_dirty | input | 1 | Matching page is writable |
| tlb_paddr | input | 32 | Physical address from the TLB |
| seed_wr | input | 1 | Load the preserved fields |
| seed_ctx_base | input | 9 | Context base field |
| seed_asid | input | 8 | Entry-hi ID field |
| out_valid | output | 1 | Result strobe |
| paddr | output | 32 | Physical address |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| fault | output | 1 | Fault strobe |
| exc_code | output | 3 | Fault kind, 0 for none |
| refill | output | 1 | Fault came from a TLB miss |
| bad_vaddr | output | 32 | Captured faulting address |
| context_reg | output | 32 | Context register |
| entry_hi | output | 32 | Entry-hi register |

## Verification
The assertions assume that the TLB response is stable and defined during any cycle in which `tlb_req` is high. They also assume that `vaddr` and the mode flags stay fixed for the whole cycle in which `req_valid` is high. The bench drives every input on the falling edge and holds it until the next falling edge, so each request sees one steady set of inputs. TLB response values are supplied on unmapped requests as well, and are sometimes contradictory there. That stimulus stays within the assumptions, because the decoder must ignore the response whenever it has not raised `tlb_req`.

// File: rtl/segment_xlate.sv
module segment_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] vaddr,
  input  logic        is_write,
  input  logic        user_mode,
  input  logic        err_level,
  output logic        tlb_req,
  output logic [31:0] tlb_vaddr,
  input  logic        tlb_hit,
  input  logic        tlb_valid,
  input  logic        tlb_dirty,
  input  logic [31:0] tlb_paddr,
  input  logic        seed_wr,
  input  logic [8:0]  seed_ctx_base,
  input  logic [7:0]  seed_asid,
  output logic        out_valid,
  output logic [31:0] paddr,
  output logic        perm_rd,
  output logic        perm_wr,
  output logic        fault,
  output logic [2:0]  exc_code,
  output logic        refill,
  output logic [31:0] bad_vaddr,
  output logic [31:0] context_reg,
  output logic [31:0] entry_hi
);

  localparam logic [2:0] EX_NONE   = 3'd0;
  localparam logic [2:0] EX_ADR_LD = 3'd1;
  localparam logic [2:0] EX_ADR_ST = 3'd2;
  localparam logic [2:0] EX_TLB_LD = 3'd3;
  localparam logic [2:0] EX_TLB_ST = 3'd4;
  localparam logic [2:0] EX_MODIFY = 3'd5;

  logic        addr_err, ident, direct, mapped;
  logic [31:0] n_paddr;
  logic        n_rd, n_wr, n_refill;
  logic [2:0]  n_exc;
  logic [8:0]  ctx_base;
  logic [18:0] vpn2;
  logic [7:0]  asid;

  assign addr_err = user_mode & vaddr[31];
  assign ident    = ~vaddr[31] & err_level;
  assign direct   = ~addr_err & vaddr[31] & ~vaddr[30];
  assign mapped   = ~addr_err & ((~vaddr[31] & ~err_level) | (vaddr[31] & vaddr[30]));

  assign tlb_req   = req_valid & mapped;
  assign tlb_vaddr = vaddr;

  always_comb begin
    n_paddr  = '0;
    n_rd     = 1'b0;
    n_wr     = 1'b0;
    n_refill = 1'b0;
    n_exc    = EX_NONE;
    if (addr_err) begin
      n_exc = is_write ? EX_ADR_ST : EX_ADR_LD;
    end else if (ident) begin
      n_paddr = vaddr;
      n_rd    = 1'b1;
      n_wr    = 1'b1;
    end else if (direct) begin
      n_paddr = {3'b000, vaddr[28:0]};
      n_rd    = 1'b1;
      n_wr    = 1'b1;
    end else if (!tlb_hit) begin
      n_exc    = is_write ? EX_TLB_ST : EX_TLB_LD;
      n_refill = 1'b1;
    end else if (!tlb_valid) begin
      n_exc = is_write ? EX_TLB_ST : EX_TLB_LD;
    end else if (is_write && !tlb_dirty) begin
      n_exc = EX_MODIFY;
    end else begin
      n_paddr = tlb_paddr;
      n_rd    = 1'b1;
      n_wr    = tlb_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      paddr     <= '0;
      perm_rd   <= 1'b0;
      perm_wr   <= 1'b0;
      fault     <= 1'b0;
      exc_code  <= EX_NONE;
      refill    <= 1'b0;
    end else begin
      out_valid <= req_valid;
      paddr     <= req_valid ? n_paddr : '0;
      perm_rd   <= req_valid & n_rd;
      perm_wr   <= req_valid & n_wr;
      fault     <= req_valid & (n_exc != EX_NONE);
      exc_code  <= req_valid ? n_exc : EX_NONE;
      refill    <= req_valid & n_refill;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_vaddr <= '0;
      vpn2      <= '0;
      ctx_base  <= '0;
      asid      <= '0;
    end else begin
      if (req_valid && n_exc != EX_NONE) begin
        bad_vaddr <= vaddr;
        vpn2      <= vaddr[31:13];
      end
      if (seed_wr) begin
        ctx_base <= seed_ctx_base;
        asid     <= seed_asid;
      end
    end
  end

  assign context_reg = {ctx_base, vpn2, 4'b0000};
  assign entry_hi    = {vpn2, 5'b00000, asid};

  // R1
  user_kernel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && vaddr[31]) |-> !tlb_req);
  // R1
  user_fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && vaddr[31]) |=> (fault && !refill && (exc_code == 3'd1 || exc_code == 3'd2)));
  // R4
  direct_no_tlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !user_mode && vaddr[31:30] == 2'b10) |=> (!fault && perm_rd && perm_wr && paddr[31:29] == 3'b000));
  // R6
  refill_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill |-> (fault && (exc_code == 3'd3 || exc_code == 3'd4)));
  // R6
  write_implies_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_wr |-> perm_rd);
  // R7
  bad_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> bad_vaddr == $past(vaddr));
  // R8
  context_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> context_reg[22:4] == $past(vaddr[31:13]));
  // R9
  entry_hi_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> entry_hi[31:13] == $past(vaddr[31:13]));
  // R10
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> ($stable(bad_vaddr) && $stable(entry_hi[31:13])));
  // R10
  fault_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!perm_rd && !perm_wr && paddr == 32'd0 && exc_code != 3'd0));
  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid));
  // R11
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(seed_wr) |-> ($stable(entry_hi[7:0]) && $stable(context_reg[31:23])));

endmodule

// File: tb/segment_xlate_tb.sv
module segment_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_write = 1'b0, user_mode = 1'b0, err_level = 1'b0;
  logic        tlb_req;
  logic [31:0] tlb_vaddr;
  logic        tlb_hit = 1'b0, tlb_valid = 1'b0, tlb_dirty = 1'b0;
  logic [31:0] tlb_paddr = '0;
  logic        seed_wr = 1'b0;
  logic [8:0]  seed_ctx_base = '0;
  logic [7:0]  seed_asid = '0;
  logic        out_valid, perm_rd, perm_wr, fault, refill;
  logic [31:0] paddr, bad_vaddr, context_reg, entry_hi;
  logic [2:0]  exc_code;

  always #5 clk = ~clk;

  segment_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .is_write(is_write), .user_mode(user_mode), .err_level(err_level),
    .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr), .tlb_hit(tlb_hit),
    .tlb_valid(tlb_valid), .tlb_dirty(tlb_dirty), .tlb_paddr(tlb_paddr),
    .seed_wr(seed_wr), .seed_ctx_base(seed_ctx_base), .seed_asid(seed_asid),
    .out_valid(out_valid), .paddr(paddr), .perm_rd(perm_rd), .perm_wr(perm_wr),
    .fault(fault), .exc_code(exc_code), .refill(refill),
    .bad_vaddr(bad_vaddr), .context_reg(context_reg), .entry_hi(entry_hi)
  );

  typedef struct {
    logic [31:0] pa;
    logic        rd, wr, flt, rf;
    logic [2:0]  ec;
    logic [31:0] bad, ctx, ehi;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   errors  = 0;
  bit   done    = 1'b0;

  logic [31:0] m_bad  = '0;
  logic [18:0] m_vpn  = '0;
  logic [8:0]  m_base = '0;
  logic [7:0]  m_asid = '0;

  function automatic logic [31:0] m_ctx();
    return {m_base, m_vpn, 4'b0000};
  endfunction
  function automatic logic [31:0] m_ehi();
    return {m_vpn, 5'b00000, m_asid};
  endfunction

  task automatic send(input logic [31:0] a, input bit w, input bit u, input bit e,
                      input bit h, input bit v, input bit d, input logic [31:0] tp,
                      input string tag);
    exp_t x;
    bit   map;
    @(negedge clk);
    req_valid = 1'b1; vaddr = a; is_write = w; user_mode = u; err_level = e;
    tlb_hit = h; tlb_valid = v; tlb_dirty = d; tlb_paddr = tp;
    x.pa = '0; x.rd = 0; x.wr = 0; x.flt = 0; x.rf = 0; x.ec = 3'd0; x.tag = tag;
    map = 0;
    if (u && a[31]) begin
      x.flt = 1; x.ec = w ? 3'd2 : 3'd1;
    end else if (!a[31] && e) begin
      x.pa = a; x.rd = 1; x.wr = 1;
    end else if (a[31:29] == 3'b100) begin
      x.pa = a - 32'h8000_0000; x.rd = 1; x.wr = 1;
    end else if (a[31:29] == 3'b101) begin
      x.pa = a - 32'hA000_0000; x.rd = 1; x.wr = 1;
    end else begin
      map = 1;
      if (!h) begin x.flt = 1; x.ec = w ? 3'd4 : 3'd3; x.rf = 1; end
      else if (!v) begin x.flt = 1; x.ec = w ? 3'd4 : 3'd3; end
      else if (w && !d) begin x.flt = 1; x.ec = 3'd5; end
      else begin x.pa = tp; x.rd = 1; x.wr = d; end
    end
    if (x.flt) begin m_bad = a; m_vpn = a[31:13]; end
    x.bad = m_bad; x.ctx = m_ctx(); x.ehi = m_ehi();
    q.push_back(x);
    #1;
    vectors++;
    if (tlb_req !== map || tlb_vaddr !== a) begin
      errors++;
      $display("FAIL R2/R5 tlb_req %s: got req=%0b addr=%h exp req=%0b addr=%h", tag, tlb_req, tlb_vaddr, map, a);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    tlb_hit = 1'b1; tlb_valid = 1'b0; tlb_dirty = 1'b0;
  endtask

  task automatic seed(input logic [8:0] b, input logic [7:0] id);
    @(negedge clk);
    req_valid = 1'b0; seed_wr = 1'b1; seed_ctx_base = b; seed_asid = id;
    m_base = b; m_asid = id;
    @(negedge clk);
    seed_wr = 1'b0;
    vectors++;
    if (context_reg !== m_ctx() || entry_hi !== m_ehi()) begin
      errors++;
      $display("FAIL R11 seed: got ctx=%h ehi=%h exp ctx=%h ehi=%h", context_reg, entry_hi, m_ctx(), m_ehi());
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result: got out_valid=1 exp none");
      end else begin
        exp_t x;
        x = q.pop_front();
        vectors++;
        if (paddr !== x.pa || perm_rd !== x.rd || perm_wr !== x.wr || fault !== x.flt ||
            exc_code !== x.ec || refill !== x.rf) begin
          errors++;
          $display("FAIL %s result: got pa=%h rd=%0b wr=%0b f=%0b ec=%0d rf=%0b exp pa=%h rd=%0b wr=%0b f=%0b ec=%0d rf=%0b",
                   x.tag, paddr, perm_rd, perm_wr, fault, exc_code, refill,
                   x.pa, x.rd, x.wr, x.flt, x.ec, x.rf);
        end
        if (bad_vaddr !== x.bad || context_reg !== x.ctx || entry_hi !== x.ehi) begin
          errors++;
          $display("FAIL %s R7/R8/R9 capture: got bad=%h ctx=%h ehi=%h exp bad=%h ctx=%h ehi=%h",
                   x.tag, bad_vaddr, context_reg, entry_hi, x.bad, x.ctx, x.ehi);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || fault !== 1'b0 || bad_vaddr !== 32'd0 ||
        context_reg !== 32'd0 || entry_hi !== 32'd0 || exc_code !== 3'd0) begin
      errors++;
      $display("FAIL R10 reset: got ov=%0b f=%0b bad=%h ctx=%h ehi=%h exp all zero",
               out_valid, fault, bad_vaddr, context_reg, entry_hi);
    end

    send(32'h0040_1234, 0, 1, 0, 1, 1, 1, 32'h1F40_1234, "R2 user low mapped hit");
    send(32'h8000_1000, 0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, "R4 window0 ignores miss");
    send(32'hBFC0_0010, 1, 0, 0, 1, 0, 0, 32'h1234_5678, "R4 window1 write");
    send(32'h1234_5678, 1, 0, 1, 0, 0, 0, 32'h0, "R3 error-level identity");
    send(32'h1234_5678, 0, 1, 1, 1, 1, 0, 32'h0, "R3 error-level identity user");
    idle();
    send(32'h8000_0000, 0, 1, 0, 1, 1, 1, 32'h0, "R1 user load kernel");
    send(32'hC000_0000, 1, 1, 0, 1, 1, 1, 32'h0, "R1 user store kernel");
    idle();
    seed(9'h1A5, 8'h3C);
    send(32'hC001_2345, 0, 0, 0, 0, 0, 0, 32'h0, "R6 R8 R9 load miss refill");
    send(32'h7FFF_E000, 1, 1, 0, 0, 1, 1, 32'h0, "R6 store miss refill");
    send(32'hE000_0004, 0, 0, 0, 1, 0, 1, 32'h0, "R6 load invalid");
    send(32'hF123_4000, 1, 0, 0, 1, 0, 1, 32'h0, "R6 store invalid");
    send(32'h0000_2000, 1, 0, 0, 1, 1, 0, 32'h0, "R6 store clean modify");
    send(32'h0000_2000, 0, 0, 0, 1, 1, 0, 32'h0055_6000, "R6 R10 load clean holds capture");
    send(32'hC0FF_EE00, 1, 0, 0, 1, 1, 1, 32'h0ABC_DE00, "R5 kernel top mapped store");
    idle();
    seed(9'h0F0, 8'hA5);
    send(32'h9FFF_FFFF, 0, 0, 0, 1, 1, 1, 32'h0, "R4 window0 upper edge");
    send(32'hA000_0000, 0, 0, 0, 1, 1, 1, 32'h0, "R4 window1 lower edge");
    send(32'hBFFF_FFFF, 1, 0, 0, 0, 1, 1, 32'h0, "R4 window1 upper edge");
    send(32'h7FFF_FFFF, 0, 1, 0, 1, 1, 0, 32'h0333_3333, "R2 user top of low half");
    send(32'h8000_0000, 0, 0, 1, 0, 0, 0, 32'h0, "R4 window0 with error level");
    send(32'hFFFF_FFFF, 0, 0, 1, 0, 0, 0, 32'h0, "R5 R8 top address miss");
    send(32'hC000_0000, 0, 0, 0, 1, 1, 1, 32'h0000_1000, "R5 lower edge hit");
    idle();
    repeat (3) @(negedge clk);
    vectors++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing results: got %0d pending exp 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule